// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block is the digital control core of a synchronous buck power stage. It receives a PWM command that analog comparators have already split into a "high region" flag and a "low region" flag. It also receives an active-low disable, an active-low diode-emulation enable, a zero-crossing comparator flag, a gate-voltage-low flag for each switch, a supply-good flag and two temperature comparator flags. From these inputs it produces the two gate enables and an active-low thermal warning.

A gate is switched on only after the opposite gate has been seen low and a minimum dead interval has passed. A PWM level held in the mid (tri-state) region longer than a hold-off time parks both switches off. In diode-emulation mode the low side is released once the inductor current reaches zero, after a blanking interval. Disable and undervoltage override every other decision.

All timing intervals are parameters counted in clock cycles: `HOLDOFF_CYC`, `DEAD_CYC`, `MIN_ON_CYC` and `BLANK_CYC`. The PWM region flags are registered once, so every decision is based on a command that is one cycle old.

Top module: `hb_gate_ctrl`

## Requirements
- R1: High region only (`pwm_hi`=1, `pwm_lo`=0) makes the low gate drop 2 cycles after the input and the high gate rise `DEAD_CYC` cycles later. Low region only is the mirror image.
- R2: A gate rises only after at least `DEAD_CYC` cycles in its waiting state and while the opposite gate-low flag is 1. If that flag stays 0, the gate waits indefinitely. Once the flag returns and the interval has already elapsed, the gate rises one cycle later.
- R3: `hs_on` and `ls_on` are never 1 in the same cycle.
- R4: Both region flags at 0, or both at 1, form the mid region. A mid run of `HOLDOFF_CYC` consecutive cycles turns both gates off one cycle after the run completes. A shorter run leaves the previous command in force.
- R5: Leaving the parked state into a valid region turns the first gate on only through the dead-time wait, `2+DEAD_CYC` cycles after the input.
- R6: Once the high gate is on, it stays on for at least `MIN_ON_CYC` cycles, even for a one-cycle high pulse. This does not apply when disable or undervoltage forces it off.
- R7: With `de_en_n`=0, the low region in force, and `zc_neg`=1, the low gate turns off after it has been on for `BLANK_CYC` cycles. With `zc_neg`=0, or with `de_en_n`=1, the low gate stays on.
- R8: `dis_n`=0 drops both gates in the same cycle and holds the sequencer idle. After release, the commanded gate rises `DEAD_CYC+1` cycles later.
- R9: `supply_ok`=0 clamps both gates low in the same cycle, with the same idle and recovery behaviour as R8.
- R10: `temp_hot`=1 drives `therm_warn_n` to 0 one cycle later. `temp_cool`=1 with `temp_hot`=0 returns it to 1. With neither flag set it holds its value. The warning never changes the gate outputs.
- R11: During reset, both gates are 0 and `therm_warn_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | PWM above the high threshold |
| pwm_lo | input | 1 | PWM below the low threshold |
| dis_n | input | 1 | Active-low disable |
| de_en_n | input | 1 | Active-low diode-emulation enable |
| zc_neg | input | 1 | Inductor current zero or negative |
| hs_gate_low | input | 1 | High-side gate voltage below turn-off level |
| ls_gate_low | input | 1 | Low-side gate voltage below turn-off level |
| supply_ok | input | 1 | Logic supply above the undervoltage threshold |
| temp_hot | input | 1 | Junction above the warning set point |
| temp_cool | input | 1 | Junction below the warning clear point |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| therm_warn_n | output | 1 | Active-low thermal warning |

## Verification
Each result has a fixed latency, counted in falling edges after the input is driven on a falling edge:
- The old gate drops after 2 edges.
- The new gate rises after 2+DEAD_CYC edges.
- The tri-state park takes effect after HOLDOFF_CYC+1 edges.
- The diode-emulation release takes effect BLANK_CYC edges after the low gate rose.
- The thermal flag changes after 1 edge.
- Disable and undervoltage act within the same cycle.

The bench samples exactly at each of these edges. Where possible it also samples one edge earlier, so that an early or late transition is reported as a failure. The minimum on-time is measured by counting high cycles of `hs_on` over a window. Gate overlap is watched on every cycle.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
    typedef enum logic [1:0] {
        CMD_OFF = 2'd0,
        CMD_HI  = 2'd1,
        CMD_LO  = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HS_WAIT = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_LS_WAIT = 3'd3,
        ST_LS_ON   = 3'd4,
        ST_DE_OFF  = 3'd5
    } seq_e;
endpackage

// File: rtl/hb_pwm_qual.sv
module hb_pwm_qual
    import hb_gate_pkg::*;
#(
    parameter int HOLDOFF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_lo,
    output cmd_e cmd_o
);
    localparam int HW = $clog2(HOLDOFF_CYC + 1);
    localparam logic [HW-1:0] CNT_SAT  = HW'(HOLDOFF_CYC);
    localparam logic [HW-1:0] CNT_LAST = HW'(HOLDOFF_CYC - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        cmd_e          cmd;
    } qual_t;

    qual_t q_q, q_d;
    logic  mid;

    always_comb begin
        mid = (pwm_hi == pwm_lo);
        q_d = q_q;
        if (!mid) begin
            q_d.cnt = '0;
            q_d.cmd = pwm_hi ? CMD_HI : CMD_LO;
        end else begin
            q_d.cnt = (q_q.cnt == CNT_SAT) ? q_q.cnt : q_q.cnt + 1'b1;
            if (q_q.cnt >= CNT_LAST) q_d.cmd = CMD_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{cnt: '0, cmd: CMD_OFF};
        else        q_q <= q_d;
    end

    assign cmd_o = q_q.cmd;

    // R1: a clean high region becomes the high command on the next cycle
    p_region_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi && !pwm_lo) |=> (cmd_o == CMD_HI));
    // R4: parking is entered only out of the mid region
    p_park_from_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_OFF) && ($past(cmd_o) != CMD_OFF)) |-> $past(pwm_hi == pwm_lo));
endmodule

// File: rtl/hb_therm_flag.sv
module hb_therm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot,
    input  logic temp_cool,
    output logic warn_o
);
    typedef struct packed {
        logic warn;
    } th_t;

    th_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (temp_hot)       t_d.warn = 1'b1;
        else if (temp_cool) t_d.warn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{warn: 1'b0};
        else        t_q <= t_d;
    end

    assign warn_o = t_q.warn;

    p_warn_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hot |=> warn_o);
    p_warn_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_cool && !temp_hot) |=> !warn_o);
    p_warn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!temp_cool && !temp_hot) |=> $stable(warn_o));
endmodule

// File: rtl/hb_sequencer.sv
module hb_sequencer
    import hb_gate_pkg::*;
#(
    parameter int DEAD_CYC   = 2,
    parameter int MIN_ON_CYC = 3,
    parameter int BLANK_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic run,
    input  logic de_en,
    input  logic zc_neg,
    input  logic hs_low,
    input  logic ls_low,
    output logic hs_req,
    output logic ls_req
);
    localparam int TMAX_A = (DEAD_CYC > MIN_ON_CYC) ? DEAD_CYC : MIN_ON_CYC;
    localparam int TMAX   = (TMAX_A > BLANK_CYC) ? TMAX_A : BLANK_CYC;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_SAT = TW'(TMAX);

    typedef struct packed {
        seq_e          st;
        logic [TW-1:0] tmr;
    } seq_t;

    seq_t s_q, s_d;

    function automatic logic elapsed(input logic [TW-1:0] t, input int unsigned n);
        return (32'(t) + 32'd1) >= n;
    endfunction

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd == CMD_HI)      s_d.st = ST_HS_WAIT;
                else if (cmd == CMD_LO) s_d.st = ST_LS_WAIT;
            end
            ST_HS_WAIT: begin
                if (cmd == CMD_OFF) s_d.st = ST_IDLE;
                else if (elapsed(s_q.tmr, DEAD_CYC) && ls_low) s_d.st = ST_HS_ON;
            end
            ST_HS_ON: begin
                if (elapsed(s_q.tmr, MIN_ON_CYC)) begin
                    if (cmd == CMD_LO)       s_d.st = ST_LS_WAIT;
                    else if (cmd == CMD_OFF) s_d.st = ST_IDLE;
                end
            end
            ST_LS_WAIT: begin
                if (cmd == CMD_OFF)     s_d.st = ST_IDLE;
                else if (cmd == CMD_HI) s_d.st = ST_HS_WAIT;
                else if (elapsed(s_q.tmr, DEAD_CYC) && hs_low) s_d.st = ST_LS_ON;
            end
            ST_LS_ON: begin
                if (cmd == CMD_HI)       s_d.st = ST_HS_WAIT;
                else if (cmd == CMD_OFF) s_d.st = ST_IDLE;
                else if (de_en && zc_neg && elapsed(s_q.tmr, BLANK_CYC)) s_d.st = ST_DE_OFF;
            end
            ST_DE_OFF: begin
                if (cmd == CMD_HI)       s_d.st = ST_HS_WAIT;
                else if (cmd == CMD_OFF) s_d.st = ST_IDLE;
                else if (!de_en)         s_d.st = ST_LS_WAIT;
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (!run) s_d.st = ST_IDLE;
        if (s_d.st != s_q.st)    s_d.tmr = '0;
        else if (s_q.tmr != T_SAT) s_d.tmr = s_q.tmr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, tmr: '0};
        else        s_q <= s_d;
    end

    assign hs_req = (s_q.st == ST_HS_ON);
    assign ls_req = (s_q.st == ST_LS_ON);

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_req && ls_req));
    p_hs_after_ls_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_req) |-> $past(ls_low));
    p_ls_after_hs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_req) |-> $past(hs_low));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int HOLDOFF_CYC = 8,
    parameter int DEAD_CYC    = 2,
    parameter int MIN_ON_CYC  = 3,
    parameter int BLANK_CYC   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic dis_n,
    input  logic de_en_n,
    input  logic zc_neg,
    input  logic hs_gate_low,
    input  logic ls_gate_low,
    input  logic supply_ok,
    input  logic temp_hot,
    input  logic temp_cool,
    output logic hs_on,
    output logic ls_on,
    output logic therm_warn_n
);
    cmd_e cmd;
    logic run;
    logic hs_req, ls_req;
    logic warn;

    assign run = dis_n && supply_ok;

    hb_pwm_qual #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_hi (pwm_hi),
        .pwm_lo (pwm_lo),
        .cmd_o  (cmd)
    );

    hb_sequencer #(
        .DEAD_CYC   (DEAD_CYC),
        .MIN_ON_CYC (MIN_ON_CYC),
        .BLANK_CYC  (BLANK_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .run    (run),
        .de_en  (!de_en_n),
        .zc_neg (zc_neg),
        .hs_low (hs_gate_low),
        .ls_low (ls_gate_low),
        .hs_req (hs_req),
        .ls_req (ls_req)
    );

    hb_therm_flag u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_hot  (temp_hot),
        .temp_cool (temp_cool),
        .warn_o    (warn)
    );

    // Immediate clamp: gates are gated by the run condition without a register
    assign hs_on        = hs_req && run;
    assign ls_on        = ls_req && run;
    assign therm_warn_n = !warn;

    p_dis_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_n |=> (!hs_req && !ls_req));
    p_uv_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_req && !ls_req));
endmodule

// File: tb/test_hb_gate_ctrl.sv
module test_hb_gate_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HOLD  = 8;
    localparam int DEAD  = 2;
    localparam int MINON = 3;
    localparam int BLANK = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_hi = 1'b0, pwm_lo = 1'b0, dis_n = 1'b1, de_en_n = 1'b1, zc_neg = 1'b1;
    logic supply_ok = 1'b1, temp_hot = 1'b0, temp_cool = 1'b0;
    logic ls_busy = 1'b0;
    logic hs_gate_low, ls_gate_low;
    logic hs_on, ls_on, therm_warn_n;

    int n_chk = 0;
    int n_bad = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign hs_gate_low = !hs_on;
    assign ls_gate_low = ls_busy ? 1'b0 : !ls_on;

    hb_gate_ctrl #(
        .HOLDOFF_CYC (HOLD),
        .DEAD_CYC    (DEAD),
        .MIN_ON_CYC  (MINON),
        .BLANK_CYC   (BLANK)
    ) i_hb_gate_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_hi       (pwm_hi),
        .pwm_lo       (pwm_lo),
        .dis_n        (dis_n),
        .de_en_n      (de_en_n),
        .zc_neg       (zc_neg),
        .hs_gate_low  (hs_gate_low),
        .ls_gate_low  (ls_gate_low),
        .supply_ok    (supply_ok),
        .temp_hot     (temp_hot),
        .temp_cool    (temp_cool),
        .hs_on        (hs_on),
        .ls_on        (ls_on),
        .therm_warn_n (therm_warn_n)
    );

    always @(negedge clk) if (rst_n && hs_on && ls_on) overlap++;

    // {pwm_hi, pwm_lo, temp_hot, temp_cool, exp_hs, exp_ls, exp_warn_n}, held 6 cycles each
    localparam logic [6:0] VEC [8] = '{
        7'b1000_101,
        7'b0110_010,
        7'b1000_100,
        7'b1100_100,
        7'b0101_011,
        7'b0000_011,
        7'b0000_001,
        7'b1000_101
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic hi, input logic lo);
        pwm_hi = hi;
        pwm_lo = lo;
    endtask

    initial begin
        int hcount;
        step(2);
        #1;
        chk("R11 hs in reset", hs_on, 1'b0);
        chk("R11 ls in reset", ls_on, 1'b0);
        chk("R11 warn_n in reset", therm_warn_n, 1'b1);
        rst_n = 1'b1;
        step(2);

        // table: regions, mid runs, thermal hysteresis (R1 R4 R10), zc_neg=1 ignored with de off (R7)
        for (int i = 0; i < 8; i++) begin
            {pwm_hi, pwm_lo, temp_hot, temp_cool} = VEC[i][6:3];
            step(6);
            chk($sformatf("R1/R4 vec%0d hs", i), hs_on, VEC[i][2]);
            chk($sformatf("R4/R7 vec%0d ls", i), ls_on, VEC[i][1]);
            chk($sformatf("R10 vec%0d warn_n", i), therm_warn_n, VEC[i][0]);
        end

        // R1 exact dead-time sequence from low to high
        drive(1'b0, 1'b1); step(10);
        drive(1'b1, 1'b0);
        step(1); chk("R1 ls still on after 1", ls_on, 1'b1);
        step(1); chk("R1 ls off after 2", ls_on, 1'b0); chk("R1 hs off after 2", hs_on, 1'b0);
        step(DEAD - 1); chk("R1 hs not yet on", hs_on, 1'b0);
        step(1); chk("R1 hs on after 2+DEAD", hs_on, 1'b1);

        // R2 stall while the low gate does not read low
        drive(1'b0, 1'b1); step(10);
        ls_busy = 1'b1;
        drive(1'b1, 1'b0);
        step(12); chk("R2 hs held off while ls not low", hs_on, 1'b0);
        ls_busy = 1'b0; #1;
        chk("R2 hs off at release", hs_on, 1'b0);
        step(1); chk("R2 hs on one cycle after release", hs_on, 1'b1);

        // R4 short mid run keeps the high command, full run parks
        step(5);
        drive(1'b0, 1'b0);
        for (int i = 0; i < HOLD - 1; i++) begin
            step(1); chk("R4 short mid keeps hs", hs_on, 1'b1);
        end
        drive(1'b1, 1'b0); step(3);
        drive(1'b1, 1'b1);
        step(HOLD); chk("R4 hs on at end of hold-off", hs_on, 1'b1);
        step(1); chk("R4 hs parked", hs_on, 1'b0); chk("R4 ls parked", ls_on, 1'b0);

        // R5 leaving the parked state goes through dead time
        drive(1'b0, 1'b0); step(5);
        drive(1'b0, 1'b1);
        step(1 + DEAD); chk("R5 ls not yet on", ls_on, 1'b0);
        step(1); chk("R5 ls on after 2+DEAD", ls_on, 1'b1);

        // R6 one-cycle high pulse is stretched to the minimum on-time
        step(8);
        drive(1'b1, 1'b0); step(1); drive(1'b0, 1'b1);
        hcount = 0;
        for (int i = 0; i < 14; i++) begin
            step(1);
            if (hs_on) hcount++;
        end
        n_chk++;
        if (hcount != MINON) begin
            n_bad++;
            $display("FAIL R6 hs high cycles: got %0d expected %0d", hcount, MINON);
        end
        chk("R6 ls back on", ls_on, 1'b1);

        // R7 diode emulation with negative current
        drive(1'b1, 1'b0); step(10);
        de_en_n = 1'b0; zc_neg = 1'b1;
        drive(1'b0, 1'b1);
        step(2 + DEAD); chk("R7 ls on after handover", ls_on, 1'b1);
        step(BLANK - 1); chk("R7 ls on through blanking", ls_on, 1'b1);
        step(1); chk("R7 ls off after blanking", ls_on, 1'b0); chk("R7 hs stays off", hs_on, 1'b0);
        // R7 positive current keeps the low side on
        drive(1'b1, 1'b0); zc_neg = 1'b0; step(10);
        drive(1'b0, 1'b1);
        step(2 + DEAD + BLANK + 4); chk("R7 ls stays on with positive current", ls_on, 1'b1);
        de_en_n = 1'b1; zc_neg = 1'b1;

        // R8 disable
        drive(1'b1, 1'b0); step(10);
        dis_n = 1'b0; #1;
        chk("R8 hs drops same cycle", hs_on, 1'b0);
        step(5); chk("R8 hs held off", hs_on, 1'b0); chk("R8 ls held off", ls_on, 1'b0);
        dis_n = 1'b1; #1;
        chk("R8 hs off at release", hs_on, 1'b0);
        step(DEAD); chk("R8 hs still off", hs_on, 1'b0);
        step(1); chk("R8 hs back on", hs_on, 1'b1);

        // R9 undervoltage
        step(5);
        supply_ok = 1'b0; #1;
        chk("R9 hs clamped same cycle", hs_on, 1'b0);
        step(5); chk("R9 ls held off", ls_on, 1'b0);
        supply_ok = 1'b1; #1;
        step(DEAD); chk("R9 hs still off", hs_on, 1'b0);
        step(1); chk("R9 hs back on", hs_on, 1'b1);

        // R3 overlap over the whole run
        n_chk++;
        if (overlap != 0) begin
            n_bad++;
            $display("FAIL R3 overlap cycles: got %0d expected 0", overlap);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule